// File: doc/BRIEF.md
# List Decoder Path Pruning Unit

This block keeps the surviving decoding paths of a successive cancellation list decoder for polar codes with a list of four paths. It holds one accumulated path metric per path. On each decoded bit the caller supplies, for every path, the magnitude and sign of that path's bit likelihood ratio, and a flag that says whether the bit is frozen or carries information. The block then updates the metrics and reports what each list slot holds after the step.

On an information bit every path forks into a 0 branch and a 1 branch. Each branch costs nothing when it agrees with the hard decision and costs the LLR magnitude when it does not. The eight branch metrics are ranked, and the four cheapest become the new list in ascending order. For each slot the block reports the index of the parent path and the decided bit, so the caller copies path indices and does not move stored bits. On a frozen bit no ranking takes place: every path keeps its slot, its bit is 0, and its metric grows only when the LLR favours 1.

Top module: `pp_prune_unit`

## Requirements
- R1: After reset all path metrics are 0, `step_done` is 0, slot l reports parent l, and all decided bits are 0.
- R2: `cw_start` clears every path metric to 0 at the next edge and takes precedence over `step_go`. A step requested in the same cycle is dropped: no `step_done` follows, and the parents and bits stay as they were.
- R3: A branch with bit b costs 0 when b equals `llr_sign` and costs `llr_mag` otherwise. A sign of 1 means a negative LLR, which favours bit 1.
- R4: On an information step the candidate with index 2p+b has metric pm[p] plus the cost of bit b on path p.
- R5: After an information step, slots 0 to 3 hold the four smallest candidate metrics in ascending order, and `surv_pm` shows them.
- R6: Among equal metrics the candidate with the lower index 2p+b ranks first. This means the lower path index wins, and the 0 branch wins over the 1 branch of the same path.
- R7: For each slot s the unit reports the parent path p in `surv_parent[2s+1:2s]` and the branch bit b in `surv_bit[s]` of the candidate it holds.
- R8: On a frozen step (`info_bit`=0) slot s keeps parent s and bit 0, and its metric grows by `llr_mag` only when `llr_sign` is 1.
- R9: A path metric saturates at 2^PM_W-1 and does not wrap around.
- R10: `step_done` is high for exactly one cycle, in the cycle after an accepted `step_go`. All survivor outputs hold their values until the next accepted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_start | input | 1 | New codeword: clear path metrics |
| step_go | input | 1 | Process one decoded bit |
| info_bit | input | 1 | 1 = information bit, 0 = frozen bit |
| llr_mag | input | 4*MAG_W | Per-path LLR magnitude; path p in bits [p*MAG_W +: MAG_W] |
| llr_sign | input | 4 | Per-path LLR sign, 1 = negative |
| step_done | output | 1 | One-cycle pulse when the step result is valid |
| surv_parent | output | 8 | Parent path index per slot, 2 bits each |
| surv_bit | output | 4 | Decided bit per slot |
| surv_pm | output | 4*PM_W | Path metric per slot |

## Verification
The hardest cases to reach are ties, because equal metrics decide both the slot order and the parent choice. The bench forces them by drawing many LLR magnitudes from the range 0 to 3, and by running steps where every magnitude is zero. The saturation corner needs long codewords, so one sweep uses full-scale magnitudes with negative signs over many frozen and information steps until the metrics stay at their ceiling. A reference list model is compared against the unit after every step.

// File: rtl/pp_pkg.sv
// Shared definitions for the path pruning unit.
// Assumes the list size is a power of two.
package pp_pkg;
    typedef enum logic {
        STEP_FROZEN = 1'b0,
        STEP_INFO   = 1'b1
    } step_kind_e;
endpackage

// File: rtl/pp_branch_cost.sv
// Expands one path into its 0 and 1 branch metrics.
// A branch that disagrees with the LLR sign adds the magnitude.
// Sums saturate at the top of the metric range.
module pp_branch_cost #(
    parameter int MAG_W = 6,
    parameter int PM_W  = 8
) (
    input  logic [PM_W-1:0]  pm,
    input  logic [MAG_W-1:0] mag,
    input  logic             sgn,
    output logic [PM_W-1:0]  exp0,
    output logic [PM_W-1:0]  exp1
);
    localparam logic [PM_W:0] PM_MAX = {1'b0, {PM_W{1'b1}}};

    logic [PM_W:0] sum_full;

    // Branch metrics with saturating addition.
    always_comb begin
        sum_full = {1'b0, pm} + (PM_W+1)'(mag);
        if (sum_full > PM_MAX) sum_full = PM_MAX;
        exp0 = sgn ? sum_full[PM_W-1:0] : pm;
        exp1 = sgn ? pm : sum_full[PM_W-1:0];
    end
endmodule

// File: rtl/pp_rank_select.sv
// Ranks N_CAND candidate metrics and names the candidate for each of the
// first N_KEEP ranks. Ties go to the lower candidate index.
// Assumes N_KEEP <= N_CAND.
module pp_rank_select #(
    parameter int N_CAND = 8,
    parameter int N_KEEP = 4,
    parameter int PM_W   = 8
) (
    input  logic [N_CAND*PM_W-1:0]           cand_pm,
    output logic [N_KEEP*$clog2(N_CAND)-1:0] sel_idx
);
    localparam int CW = $clog2(N_CAND);
    localparam int RW = CW + 1;

    logic [RW-1:0] rank [N_CAND];

    // Rank of each candidate = number of candidates ordered before it.
    always_comb begin
        for (int c = 0; c < N_CAND; c++) begin
            rank[c] = '0;
            for (int k = 0; k < N_CAND; k++) begin
                if (k != c) begin
                    if ((cand_pm[k*PM_W +: PM_W] < cand_pm[c*PM_W +: PM_W]) ||
                        ((cand_pm[k*PM_W +: PM_W] == cand_pm[c*PM_W +: PM_W]) && (k < c)))
                        rank[c] = rank[c] + 1'b1;
                end
            end
        end
    end

    // Slot s takes the candidate whose rank is s.
    always_comb begin
        sel_idx = '0;
        for (int s = 0; s < N_KEEP; s++) begin
            for (int c = 0; c < N_CAND; c++) begin
                if (rank[c] == RW'(s)) sel_idx[s*CW +: CW] = CW'(c);
            end
        end
    end
endmodule

// File: rtl/pp_prune_unit.sv
// Path pruning unit for a list decoder with L paths.
// Keeps one metric per path, expands on information bits, keeps the L
// smallest candidates and reports parent index and bit per slot.
// On frozen bits the paths keep their slots. Result is valid one cycle
// after step_go; cw_start wins over step_go.
module pp_prune_unit #(
    parameter int L     = 4,
    parameter int MAG_W = 6,
    parameter int PM_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cw_start,
    input  logic                   step_go,
    input  logic                   info_bit,
    input  logic [L*MAG_W-1:0]     llr_mag,
    input  logic [L-1:0]           llr_sign,
    output logic                   step_done,
    output logic [L*$clog2(L)-1:0] surv_parent,
    output logic [L-1:0]           surv_bit,
    output logic [L*PM_W-1:0]      surv_pm
);
    import pp_pkg::*;

    localparam int IW     = $clog2(L);
    localparam int N_CAND = 2 * L;
    localparam int CW     = $clog2(N_CAND);

    logic [N_CAND*PM_W-1:0] cand_pm;
    logic [L*CW-1:0]        sel_idx;
    logic [L*IW-1:0]        nxt_parent;
    logic [L-1:0]           nxt_bit;
    logic [L*PM_W-1:0]      nxt_pm;
    step_kind_e             kind;
    logic                   accept;

    assign kind   = step_kind_e'(info_bit);
    assign accept = step_go && !cw_start;

    // One branch-cost expander per path; candidate 2p+b.
    for (genvar p = 0; p < L; p++) begin : g_path
        pp_branch_cost #(.MAG_W(MAG_W), .PM_W(PM_W)) u_cost (
            .pm   (surv_pm[p*PM_W +: PM_W]),
            .mag  (llr_mag[p*MAG_W +: MAG_W]),
            .sgn  (llr_sign[p]),
            .exp0 (cand_pm[(2*p)*PM_W +: PM_W]),
            .exp1 (cand_pm[(2*p+1)*PM_W +: PM_W])
        );
    end

    pp_rank_select #(.N_CAND(N_CAND), .N_KEEP(L), .PM_W(PM_W)) u_rank (
        .cand_pm (cand_pm),
        .sel_idx (sel_idx)
    );

    // Next list contents for the current step kind.
    always_comb begin
        for (int s = 0; s < L; s++) begin
            logic [CW-1:0] c;
            c = sel_idx[s*CW +: CW];
            if (kind == STEP_INFO) begin
                nxt_parent[s*IW +: IW] = c[CW-1:1];
                nxt_bit[s]             = c[0];
                nxt_pm[s*PM_W +: PM_W] = cand_pm[c*PM_W +: PM_W];
            end else begin
                nxt_parent[s*IW +: IW] = IW'(s);
                nxt_bit[s]             = 1'b0;
                nxt_pm[s*PM_W +: PM_W] = cand_pm[(2*s)*PM_W +: PM_W];
            end
        end
    end

    // Path metric registers: reset, codeword clear, step update.
    always_ff @(posedge clk) begin
        if (!rst_n || cw_start) surv_pm <= '0;
        else if (step_go)       surv_pm <= nxt_pm;
    end

    // Survivor index/bit registers and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < L; s++) surv_parent[s*IW +: IW] <= IW'(s);
            surv_bit  <= '0;
            step_done <= 1'b0;
        end else begin
            step_done <= accept;
            if (accept) begin
                surv_parent <= nxt_parent;
                surv_bit    <= nxt_bit;
            end
        end
    end

    AST_CW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cw_start |=> (surv_pm == '0 && !step_done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> step_done); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(surv_parent) && $stable(surv_bit))); // R10
    AST_FROZEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !info_bit) |=> (surv_bit == '0)); // R8
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && info_bit) |=> (surv_pm[PM_W-1:0] <= surv_pm[PM_W +: PM_W] &&
                                  surv_pm[PM_W +: PM_W] <= surv_pm[2*PM_W +: PM_W] &&
                                  surv_pm[2*PM_W +: PM_W] <= surv_pm[3*PM_W +: PM_W])); // R5

    for (genvar s = 0; s < L; s++) begin : g_chk
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !info_bit) |=>
                (surv_pm[s*PM_W +: PM_W] >= $past(surv_pm[s*PM_W +: PM_W]))); // R9
    end
endmodule

// File: tb/pp_prune_unit_test.sv
module pp_prune_unit_test;
    localparam int L = 4, MAG_W = 6, PM_W = 8;
    localparam int PM_MAX = (1 << PM_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, cw_start = 1'b0, step_go = 1'b0, info_bit = 1'b0;
    logic [L*MAG_W-1:0] llr_mag = '0;
    logic [L-1:0] llr_sign = '0;
    logic step_done;
    logic [2*L-1:0] surv_parent;
    logic [L-1:0] surv_bit;
    logic [L*PM_W-1:0] surv_pm;

    int n_tests = 0, n_fail = 0, cycles = 0;
    int m_pm [L];
    int e_par [L];
    int e_bit [L];
    int mag_a [L];
    int sgn_a [L];
    logic [31:0] rng = 32'h1234_5678;

    pp_prune_unit #(.L(L), .MAG_W(MAG_W), .PM_W(PM_W)) uut (
        .clk(clk), .rst_n(rst_n), .cw_start(cw_start), .step_go(step_go),
        .info_bit(info_bit), .llr_mag(llr_mag), .llr_sign(llr_sign),
        .step_done(step_done), .surv_parent(surv_parent), .surv_bit(surv_bit),
        .surv_pm(surv_pm));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] next_rng(logic [31:0] x);
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference list model: compute expected list after one step.
    task automatic model_step(bit info);
        int cm [2*L];
        bit used [2*L];
        int npm [L];
        for (int p = 0; p < L; p++) begin
            for (int b = 0; b < 2; b++) begin
                int v;
                v = m_pm[p] + ((b == sgn_a[p]) ? 0 : mag_a[p]);   // R3, R4
                cm[2*p+b] = (v > PM_MAX) ? PM_MAX : v;            // R9
                used[2*p+b] = 1'b0;
            end
        end
        for (int s = 0; s < L; s++) begin
            if (info) begin
                int best;
                best = -1;
                for (int c = 0; c < 2*L; c++)
                    if (!used[c] && (best < 0 || cm[c] < cm[best])) best = c;  // R6
                used[best] = 1'b1;
                e_par[s] = best / 2; e_bit[s] = best % 2; npm[s] = cm[best];
            end else begin
                e_par[s] = s; e_bit[s] = 0; npm[s] = cm[2*s];            // R8
            end
        end
        for (int s = 0; s < L; s++) m_pm[s] = npm[s];
    endtask

    task automatic check_list(string req);
        for (int s = 0; s < L; s++) begin
            check({req, " R7 parent"}, int'(surv_parent[2*s +: 2]), e_par[s]);
            check({req, " R7 bit"}, int'(surv_bit[s]), e_bit[s]);
            check({req, " R5 pm"}, int'(surv_pm[s*PM_W +: PM_W]), m_pm[s]);
        end
    endtask

    task automatic do_step(bit info, string req);
        @(negedge clk);
        for (int p = 0; p < L; p++) begin
            llr_mag[p*MAG_W +: MAG_W] = MAG_W'(mag_a[p]);
            llr_sign[p] = sgn_a[p][0];
        end
        info_bit = info; step_go = 1'b1;
        @(negedge clk);
        step_go = 1'b0;
        model_step(info);
        check("R10 done", int'(step_done), 1);
        check_list(req);
    endtask

    task automatic new_cw();
        @(negedge clk); cw_start = 1'b1;
        @(negedge clk); cw_start = 1'b0;
        for (int p = 0; p < L; p++) m_pm[p] = 0;
        for (int p = 0; p < L; p++) check("R2 clear", int'(surv_pm[p*PM_W +: PM_W]), 0);
    endtask

    task automatic rand_llr(int range, int neg_bias);
        for (int p = 0; p < L; p++) begin
            rng = next_rng(rng); mag_a[p] = int'(rng % 32'(range));
            rng = next_rng(rng); sgn_a[p] = (int'(rng % 4) < neg_bias) ? 1 : 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < L; s++) begin
            check("R1 pm", int'(surv_pm[s*PM_W +: PM_W]), 0);
            check("R1 parent", int'(surv_parent[2*s +: 2]), s);
            check("R1 bit", int'(surv_bit[s]), 0);
            m_pm[s] = 0; e_par[s] = s; e_bit[s] = 0;
        end
        check("R1 done", int'(step_done), 0);

        // R6 all-zero magnitudes: pure tie ordering
        for (int p = 0; p < L; p++) begin mag_a[p] = 0; sgn_a[p] = p % 2; end
        do_step(1'b1, "R6 tie");

        // R3/R4 hand case: distinct magnitudes, mixed signs
        new_cw();
        mag_a = '{5, 1, 7, 2}; sgn_a = '{0, 1, 1, 0};
        do_step(1'b1, "R3 hand1");
        mag_a = '{3, 3, 4, 9}; sgn_a = '{1, 0, 0, 1};
        do_step(1'b1, "R4 hand2");
        // R10 hold for a few idle cycles
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 single pulse", int'(step_done), 0);
            check_list("R10 hold");
        end
        // R8 frozen steps
        mag_a = '{6, 2, 0, 4}; sgn_a = '{1, 0, 1, 1};
        do_step(1'b0, "R8 frozen");

        // R2 cw_start with step_go in same cycle: step dropped
        @(negedge clk);
        cw_start = 1'b1; step_go = 1'b1; info_bit = 1'b1;
        @(negedge clk);
        cw_start = 1'b0; step_go = 1'b0;
        for (int p = 0; p < L; p++) m_pm[p] = 0;
        check("R2 drop done", int'(step_done), 0);
        check_list("R2 drop");

        // Sweep: small magnitudes (ties) and full range
        for (int cw = 0; cw < 300; cw++) begin
            new_cw();
            for (int st = 0; st < 16; st++) begin
                rng = next_rng(rng);
                rand_llr((cw % 2) ? 4 : 64, 2);
                do_step(rng[3] | rng[4], "R5 sweep");
            end
        end

        // R9 saturation: long codewords of large negative LLRs
        for (int cw = 0; cw < 4; cw++) begin
            new_cw();
            for (int st = 0; st < 24; st++) begin
                rand_llr(64, 4);
                for (int p = 0; p < L; p++) if (mag_a[p] < 40) mag_a[p] = 63;
                do_step(st % 3 != 0, "R9 saturate");
            end
            for (int s = 0; s < L; s++)
                check("R9 at ceiling", int'(surv_pm[s*PM_W +: PM_W]), PM_MAX);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule